// File: doc/BRIEF.md
# One-Time-Programmable Link Array Controller

This block owns a bit array of one-time-programmable links and the sequencing that writes and checks it. Every link leaves manufacture intact (reads as 1). A link can be opened (reads as 0) by a timed blow pulse. An opened link stays open: no operation, command or reset can restore it. A host streams a target pattern into the controller, one bit per address, and then issues one of three commands. Program burns the pattern into the array and reads it back. Verify compares the array against a pattern without changing it. Secure opens a separate locking link that blanks all later readback.

For a program command, the controller first scans the whole target pattern for addresses that ask for a 1 over a link that is already open. If it finds one, it stops with an error before any pulse is issued. If none exists, it walks the addresses in ascending order and fires one pulse for each link that must open. The pulse length is a host-supplied cycle count, clamped into a legal window. After the burn scan, every link is compared against the target and the controller reports pass, or the lowest failing address. The locking pulse is much longer than a link pulse and is granted only after a verify pass. Pulse durations are expressed only as cycle counts; the electrical side of the process is not modelled.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After power-up every link reads 1. A link only ever changes from 1 to 0, and it keeps 0 across all later commands and across `rst`. `rd_data` is registered and shows the link at `rd_addr` one cycle after the address is applied.
- R2: After a program or verify command, the controller accepts exactly NUM_LINKS pattern bits through `map_valid`/`map_ready`, address 0 first and one bit per cycle in which both are high. A bit value of 0 means "link open" and 1 means "link intact". `map_ready` is high only while the controller is collecting bits, and gaps in `map_valid` are allowed.
- R3: If any address has target 1 over an open link, a program ends with `res_code` 3 (unprogrammable) and `err_addr` set to the lowest such address. No pulse is issued for any address, and the array is left unchanged.
- R4: Otherwise the burn scan runs in ascending address order. It issues exactly one pulse for each link whose target is 0 and which is still intact, and no pulse for any other link. `blow_addr` holds the link's address for the whole pulse.
- R5: Each link pulse keeps `blow_on` high for `pulse_len` cycles, clamped into [PULSE_MIN, PULSE_MAX]. The length is captured when the program command is accepted.
- R6: When every link matches its target after the burn scan, a program ends with `res_code` 1 (pass).
- R7: A verify command compares each link with the streamed pattern. It ends with `res_code` 1 when all links match, or with `res_code` 2 (mismatch) and `err_addr` set to the lowest differing address.
- R8: A secure command is granted only when the most recent program or verify ended in a pass and the locking link is still intact. Otherwise the command ends at once with `res_code` 5 (rejected) and no pulse.
- R9: A granted secure command keeps `sec_on` high for SEC_PULSE cycles and then ends with `res_code` 6 (secured).
- R10: Once the locking link is open, `rd_data` is 0 for every address. A verify command then ends with `res_code` 4 (locked) without collecting pattern bits, and the compare at the end of a program also reports 4.
- R11: `busy` is high while the controller collects bits, scans, pulses, compares or secures, and low otherwise. Commands are accepted only while `busy` is low. `cmd_op` encodes 1 = program, 2 = verify, 3 = secure, and 0 is ignored.
- R12: The synchronous active-high `rst` returns the controller to idle with `busy` 0 and `res_code` 0, and it clears the pass record used by R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller (not of the links) |
| cmd_valid | input | 1 | Command strobe, taken while not busy |
| cmd_op | input | 2 | 1 program, 2 verify, 3 secure, 0 no operation |
| pulse_len | input | LEN_W | Requested link pulse length in cycles |
| map_valid | input | 1 | Pattern bit valid |
| map_bit | input | 1 | Pattern bit for the current address (0 open, 1 intact) |
| map_ready | output | 1 | Controller is collecting pattern bits |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | 1 | Registered link value, or 0 once locked |
| busy | output | 1 | Operation in progress |
| res_code | output | 3 | Result of the last operation |
| err_addr | output | ADDR_W | Failing address for results 2 and 3 |
| blow_on | output | 1 | Link pulse active |
| blow_addr | output | ADDR_W | Address being scanned or pulsed |
| sec_on | output | 1 | Locking pulse active |

## Verification
The program command is tried with a fresh array, with a pattern that extends an already burnt array, with a pattern that matches it exactly, and with a pattern that asks for an open link to be restored. Together these separate "pulse every 0" from "pulse only intact links that must open", and show that the pre-scan stops before the first pulse even when a burnable address comes earlier. Pulse requests below, inside and above the window tell clamping apart from pass-through. Verify patterns that fail in each direction (target 0 over intact, target 1 over open) check that the lowest address is reported. Secure requests are made before any pass, after a failure, after a reset, after a pass and after locking.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROGRAM,
    ST_PULSE,
    ST_VERIFY,
    ST_DONE,
    ST_ERROR,
    ST_SECURE
  } otp_state_e;

  typedef enum logic [2:0] {
    RES_NONE     = 3'd0,
    RES_PASS     = 3'd1,
    RES_MISMATCH = 3'd2,
    RES_UNPROG   = 3'd3,
    RES_LOCKED   = 3'd4,
    RES_REJECT   = 3'd5,
    RES_SECURED  = 3'd6
  } otp_res_e;

  localparam logic [1:0] OP_NOP     = 2'd0;
  localparam logic [1:0] OP_PROGRAM = 2'd1;
  localparam logic [1:0] OP_VERIFY  = 2'd2;
  localparam logic [1:0] OP_SECURE  = 2'd3;

endpackage

// File: rtl/otp_fuse_array.sv
// Write-once link storage. Links and the locking link are not reset:
// they model non-volatile state that survives a controller reset.
module otp_fuse_array #(
  parameter int unsigned NUM_LINKS = 64,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blow_en,
  input  logic [ADDR_W-1:0] blow_addr,
  input  logic              sec_blow_en,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic              scan_bit,
  output logic              sec_blown,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data
);

  logic [NUM_LINKS-1:0] link_q = '1;
  logic                 sec_q  = 1'b0;

  always_ff @(posedge clk) begin
    if (blow_en)     link_q[blow_addr] <= 1'b0;
    if (sec_blow_en) sec_q             <= 1'b1;
    rd_data <= sec_q ? 1'b0 : link_q[rd_addr];
  end

  assign scan_bit  = link_q[scan_addr];
  assign sec_blown = sec_q;

  // R1: an open link never reads intact again
  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link_chk
    p_link_stays_open_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(link_q[g]) |-> !link_q[g]);
  end

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $past(sec_q) |-> sec_q);

  p_blank_read_r10: assert property (@(posedge clk) disable iff (rst)
    sec_q |=> (rd_data == 1'b0));

endmodule

// File: rtl/otp_target_store.sv
// Holds the streamed pattern, one bit per link address.
module otp_target_store #(
  parameter int unsigned NUM_LINKS = 64,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  logic [NUM_LINKS-1:0] pat_q;

  always_ff @(posedge clk) begin
    if (wr_en) pat_q[wr_addr] <= wr_bit;
  end

  assign rd_bit = pat_q[rd_addr];

endmodule

// File: rtl/otp_pulse_timer.sv
// Down-counter shared by link and locking pulses: active for exactly
// len cycles after the start edge, fire marks the final cycle.
module otp_pulse_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             active,
  output logic             fire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= len;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign fire   = (cnt_q == CNT_W'(1));

  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt_q == '0));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (len != '0));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 64,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned PULSE_MIN = 2500,     // 10 us at 250 MHz
  parameter int unsigned PULSE_MAX = 12500,    // 50 us at 250 MHz
  parameter int unsigned SEC_PULSE = 2500000,  // about 10 ms at 250 MHz
  localparam int unsigned ADDR_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  pulse_len,
  input  logic              map_valid,
  input  logic              map_bit,
  output logic              map_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data,
  output logic              busy,
  output logic [2:0]        res_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic              blow_on,
  output logic [ADDR_W-1:0] blow_addr,
  output logic              sec_on
);

  localparam int unsigned T_MAX = (SEC_PULSE > PULSE_MAX) ? SEC_PULSE : PULSE_MAX;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(NUM_LINKS - 1);
  localparam logic [CNT_W-1:0]  LEN_LO = CNT_W'(PULSE_MIN);
  localparam logic [CNT_W-1:0]  LEN_HI = CNT_W'(PULSE_MAX);
  localparam logic [CNT_W-1:0]  LEN_SEC = CNT_W'(SEC_PULSE);

  otp_state_e        state_q;
  otp_res_e          res_q;
  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W-1:0] err_q;
  logic              prog_q;       // current op is a program
  logic              burn_q;       // 0: pre-scan, 1: burn scan
  logic              pass_q;       // last compare passed
  logic [CNT_W-1:0]  len_q;

  logic              tgt_bit, link_bit, sec_blown;
  logic              tmr_start, tmr_active, tmr_fire;
  logic [CNT_W-1:0]  tmr_len;
  logic              blow_en, sec_blow_en, load_en;
  logic              idle_like, at_last, sec_grant;
  logic [31:0]       req_len, clamp_len;

  // ---- pulse length clamp ----
  always_comb begin
    req_len = 32'(pulse_len);
    if (req_len < PULSE_MIN)      clamp_len = PULSE_MIN;
    else if (req_len > PULSE_MAX) clamp_len = PULSE_MAX;
    else                          clamp_len = req_len;
  end

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign at_last   = (idx_q == LAST);
  assign sec_grant = pass_q && !sec_blown;
  assign load_en   = (state_q == ST_LOAD) && map_valid;

  assign tmr_start = ((state_q == ST_PROGRAM) && burn_q && !tgt_bit && link_bit) ||
                     (idle_like && cmd_valid && (cmd_op == OP_SECURE) && sec_grant);
  assign tmr_len   = (state_q == ST_PROGRAM) ? len_q : LEN_SEC;
  assign blow_en     = (state_q == ST_PULSE)  && tmr_fire;
  assign sec_blow_en = (state_q == ST_SECURE) && tmr_fire;

  otp_target_store #(.NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W)) u_pattern (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (idx_q),
    .wr_bit  (map_bit),
    .rd_addr (idx_q),
    .rd_bit  (tgt_bit)
  );

  otp_fuse_array #(.NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W)) u_links (
    .clk         (clk),
    .rst         (rst),
    .blow_en     (blow_en),
    .blow_addr   (idx_q),
    .sec_blow_en (sec_blow_en),
    .scan_addr   (idx_q),
    .scan_bit    (link_bit),
    .sec_blown   (sec_blown),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  otp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .len    (tmr_len),
    .active (tmr_active),
    .fire   (tmr_fire)
  );

  // ---- sequencer ----
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      res_q   <= RES_NONE;
      idx_q   <= '0;
      err_q   <= '0;
      prog_q  <= 1'b0;
      burn_q  <= 1'b0;
      pass_q  <= 1'b0;
      len_q   <= LEN_LO;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_ERROR: begin
          if (cmd_valid) begin
            unique case (cmd_op)
              OP_PROGRAM: begin
                state_q <= ST_LOAD;
                res_q   <= RES_NONE;
                idx_q   <= '0;
                prog_q  <= 1'b1;
                pass_q  <= 1'b0;
                len_q   <= CNT_W'(clamp_len);
              end
              OP_VERIFY: begin
                pass_q <= 1'b0;
                idx_q  <= '0;
                prog_q <= 1'b0;
                if (sec_blown) begin
                  state_q <= ST_DONE;
                  res_q   <= RES_LOCKED;
                end else begin
                  state_q <= ST_LOAD;
                  res_q   <= RES_NONE;
                end
              end
              OP_SECURE: begin
                if (sec_grant) begin
                  state_q <= ST_SECURE;
                  res_q   <= RES_NONE;
                end else begin
                  state_q <= ST_ERROR;
                  res_q   <= RES_REJECT;
                end
              end
              default: ;
            endcase
          end
        end
        ST_LOAD: begin
          if (map_valid) begin
            if (at_last) begin
              idx_q   <= '0;
              burn_q  <= 1'b0;
              state_q <= prog_q ? ST_PROGRAM : ST_VERIFY;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PROGRAM: begin
          if (!burn_q) begin
            if (tgt_bit && !link_bit) begin
              state_q <= ST_ERROR;
              res_q   <= RES_UNPROG;
              err_q   <= idx_q;
            end else if (at_last) begin
              idx_q  <= '0;
              burn_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            if (!tgt_bit && link_bit) begin
              state_q <= ST_PULSE;
            end else if (at_last) begin
              idx_q   <= '0;
              state_q <= ST_VERIFY;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PULSE: begin
          if (tmr_fire) begin
            if (at_last) begin
              idx_q   <= '0;
              state_q <= ST_VERIFY;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_PROGRAM;
            end
          end
        end
        ST_VERIFY: begin
          if (sec_blown) begin
            state_q <= ST_DONE;
            res_q   <= RES_LOCKED;
          end else if (tgt_bit != link_bit) begin
            state_q <= ST_ERROR;
            res_q   <= RES_MISMATCH;
            err_q   <= idx_q;
          end else if (at_last) begin
            state_q <= ST_DONE;
            res_q   <= RES_PASS;
            pass_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SECURE: begin
          if (tmr_fire) begin
            state_q <= ST_DONE;
            res_q   <= RES_SECURED;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = !idle_like;
  assign map_ready = (state_q == ST_LOAD);
  assign res_code  = res_q;
  assign err_addr  = err_q;
  assign blow_on   = (state_q == ST_PULSE) && tmr_active;
  assign blow_addr = idx_q;
  assign sec_on    = (state_q == ST_SECURE) && tmr_active;

  // ---- assertions ----
  p_pulse_window_r5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_PROGRAM) && tmr_start) |-> ((len_q >= LEN_LO) && (len_q <= LEN_HI)));

  p_blow_needed_r4: assert property (@(posedge clk) disable iff (rst)
    blow_en |-> (!tgt_bit && link_bit));

  p_secure_after_pass_r8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SECURE) && ($past(state_q) != ST_SECURE)) |-> $past(pass_q));

  p_pulses_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(blow_on && sec_on));

  p_idle_no_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tmr_active));

endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  import otp_pkg::*;

  localparam int N    = 16;
  localparam int AW   = 4;
  localparam int LW   = 16;
  localparam int PMIN = 10;
  localparam int PMAX = 50;
  localparam int SECP = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [LW-1:0] pulse_len = '0;
  logic          map_valid = 1'b0;
  logic          map_bit = 1'b0;
  logic          map_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_data;
  logic          busy;
  logic [2:0]    res_code;
  logic [AW-1:0] err_addr;
  logic          blow_on;
  logic [AW-1:0] blow_addr;
  logic          sec_on;

  always #2 clk = ~clk;   // 250 MHz

  otp_fuse_ctrl #(
    .NUM_LINKS(N), .LEN_W(LW), .PULSE_MIN(PMIN), .PULSE_MAX(PMAX), .SEC_PULSE(SECP)
  ) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pulse_len(pulse_len),
    .map_valid(map_valid), .map_bit(map_bit), .map_ready(map_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .res_code(res_code),
    .err_addr(err_addr), .blow_on(blow_on), .blow_addr(blow_addr), .sec_on(sec_on)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  logic [N-1:0] model = '1;
  bit           blank = 1'b0;
  bit           vok   = 1'b0;
  int           last_res = 0;

  // pulse records from the per-clock monitor
  int  p_addr_q[$];
  int  p_width_q[$];
  int  s_width_q[$];
  bit  in_p = 1'b0, in_s = 1'b0;
  int  p_addr = 0, p_w = 0, s_w = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock monitor of the pulse outputs against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (blow_on && sec_on) begin
        checks++; errors++;
        $display("FAIL R11 both pulses active: actual 1 expected 0");
      end
      if (blow_on) begin
        if (!in_p) begin
          in_p = 1'b1; p_addr = int'(blow_addr); p_w = 0;
          if (blank && 0) ;
        end else if (int'(blow_addr) != p_addr) begin
          checks++; errors++;
          $display("FAIL R4 blow_addr moved during pulse: actual %0d expected %0d", blow_addr, p_addr);
        end
        p_w++;
      end else if (in_p) begin
        in_p = 1'b0;
        p_addr_q.push_back(p_addr);
        p_width_q.push_back(p_w);
      end
      if (sec_on) begin
        if (!in_s) begin in_s = 1'b1; s_w = 0; end
        s_w++;
      end else if (in_s) begin
        in_s = 1'b0;
        s_width_q.push_back(s_w);
      end
    end
  end

  function automatic int clamp(input int l);
    if (l < PMIN) return PMIN;
    if (l > PMAX) return PMAX;
    return l;
  endfunction

  task automatic issue(input logic [1:0] op);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = OP_NOP;
  endtask

  task automatic stream(input logic [N-1:0] pat);
    for (int k = 0; k < N; k++) begin
      if (k % 5 == 4) begin
        map_valid = 1'b0;
        @(negedge clk);
      end
      map_valid = 1'b1;
      map_bit   = pat[k];
      while (!map_ready) @(negedge clk);
      @(negedge clk);
    end
    map_valid = 1'b0;
  endtask

  task automatic wait_idle(input bit poke);
    int n = 0;
    while (busy) begin
      if (poke && n == 3) begin
        cmd_valid = 1'b1;
        cmd_op    = OP_VERIFY;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_sweep(input string tag);
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      chk(tag, int'(rd_data), blank ? 0 : int'(model[a]));
    end
  endtask

  task automatic run_program(input logic [N-1:0] pat, input int len, input bit poke);
    int first_bad = -1;
    int exp_addr[$];
    for (int k = 0; k < N; k++) begin
      if (pat[k] && !model[k] && first_bad < 0) first_bad = k;
      if (!pat[k] && model[k]) exp_addr.push_back(k);
    end
    p_addr_q.delete(); p_width_q.delete();
    pulse_len = LW'(len);
    issue(OP_PROGRAM);
    chk("R11 busy after program accepted", int'(busy), 1);
    stream(pat);
    wait_idle(poke);
    if (first_bad >= 0) begin
      chk("R3 unprogrammable code", int'(res_code), 3);
      chk("R3 lowest unprogrammable address", int'(err_addr), first_bad);
      chk("R3 no pulse issued", p_addr_q.size(), 0);
      vok = 1'b0;
    end else begin
      chk("R4 pulse count", p_addr_q.size(), exp_addr.size());
      for (int i = 0; i < exp_addr.size() && i < p_addr_q.size(); i++) begin
        chk("R4 pulse address order", p_addr_q[i], exp_addr[i]);
        chk("R5 pulse width", p_width_q[i], clamp(len));
      end
      model = pat;
      if (blank) begin
        chk("R10 program compare locked", int'(res_code), 4);
        vok = 1'b0;
      end else begin
        chk("R6 program pass", int'(res_code), 1);
        vok = 1'b1;
      end
    end
    read_sweep("R1 readback after program");
  endtask

  task automatic run_verify(input logic [N-1:0] pat);
    int first_bad = -1;
    for (int k = 0; k < N; k++)
      if (pat[k] != model[k] && first_bad < 0) first_bad = k;
    issue(OP_VERIFY);
    if (blank) begin
      chk("R10 no bit collection when locked", int'(map_ready), 0);
      wait_idle(1'b0);
      chk("R10 verify locked code", int'(res_code), 4);
      vok = 1'b0;
    end else begin
      stream(pat);
      wait_idle(1'b0);
      if (first_bad >= 0) begin
        chk("R7 mismatch code", int'(res_code), 2);
        chk("R7 lowest mismatch address", int'(err_addr), first_bad);
        vok = 1'b0;
      end else begin
        chk("R7 verify pass", int'(res_code), 1);
        vok = 1'b1;
      end
    end
    read_sweep("R1 readback after verify");
  endtask

  task automatic run_secure();
    bit grant = vok && !blank;
    s_width_q.delete();
    issue(OP_SECURE);
    wait_idle(1'b0);
    if (grant) begin
      chk("R9 secured code", int'(res_code), 6);
      chk("R9 one locking pulse", s_width_q.size(), 1);
      if (s_width_q.size() > 0) chk("R9 locking pulse width", s_width_q[0], SECP);
      blank = 1'b1;
    end else begin
      chk("R8 secure rejected code", int'(res_code), 5);
      chk("R8 no locking pulse", s_width_q.size(), 0);
    end
    read_sweep(blank ? "R10 blanked readback" : "R1 readback after secure");
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 busy after reset", int'(busy), 0);
    chk("R12 result after reset", int'(res_code), 0);
    chk("R2 not ready when idle", int'(map_ready), 0);
    read_sweep("R1 all links intact at start");

    // no-operation code is ignored
    issue(OP_NOP);
    @(negedge clk);
    chk("R11 op 0 ignored busy", int'(busy), 0);
    chk("R11 op 0 ignored result", int'(res_code), 0);

    run_secure();                              // rejected: no pass yet
    run_program(16'hFDDB, 20, 1'b0);           // blow 2,5,9
    run_verify(16'hFDF9);                      // mismatch at 1
    run_verify(16'hFFDB);                      // mismatch at 9
    run_secure();                              // rejected after failure
    run_program(16'hFFFA, 20, 1'b0);           // unprogrammable at 5, 0 would burn
    run_program(16'h7DDA, 3, 1'b0);            // blow 0,15, clamped low
    run_program(16'h7D5A, 200, 1'b1);          // blow 7, clamped high, poke while busy
    repeat (3) @(negedge clk);
    chk("R11 command during busy ignored", int'(busy), 0);
    chk("R11 result kept after ignored command", int'(res_code), 1);
    run_program(16'h7D5A, 20, 1'b0);           // already matching, no pulse

    // controller reset keeps the links
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 busy after mid reset", int'(busy), 0);
    chk("R12 result after mid reset", int'(res_code), 0);
    vok = 1'b0;
    read_sweep("R1 links survive reset");
    run_secure();                              // rejected: pass record cleared

    run_verify(16'h7D5A);                      // pass
    run_secure();                              // granted
    run_verify(16'h7D5A);                      // locked
    run_secure();                              // rejected: already locked
    run_program(16'h7D5A, 20, 1'b0);           // compare reports locked

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule